// File: doc/BRIEF.md
# Escape-Channel Virtual Channel Allocator

This block hands out the virtual channels (VCs) of one physical output link to messages that ask for one. Each request carries a message identifier and a direction flag. The flag says whether the current coordinate of the message is below its target coordinate. A channel stays occupied until its per-channel release strobe arrives. A parameter selects one of two deadlock-free partitioning schemes.

In the class scheme, the VCs are split into a low group and a high group. The direction flag selects which group the request may use. In the escape scheme, VC indices 2 and up are general channels that any request may take. Indices 0 and 1 are kept back as escape channels. A request falls back to an escape channel only when every general channel is occupied. The direction flag decides which escape channel it may use.

A request that finds no usable channel joins a wait list. Waiting messages take precedence over new arrivals, and the oldest waiter that can use a free channel is served first. An occupancy state machine tracks the wait list through three states:
- Q_EMPTY to Q_PART on FIRST_WAIT.
- Q_PART to Q_FULL on FILL.
- Q_PART to Q_EMPTY on DRAIN.
- Q_FULL to Q_PART on ROOM.

The Q_FULL state drives the backpressure flag.

Top module: `vc_escape_alloc`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy_o` is all zero, `grant_o` is 0 and `q_full_o` is 0.
- R2: Class scheme (`ORG`=ORG_CLASS): VC indices 0..LOW_CNT-1 form the low group and LOW_CNT..NUM_VC-1 form the high group. A request with `up_i`=1 may only get a free high-group VC, and one with `up_i`=0 may only get a free low-group VC. The lowest free eligible index wins.
- R3: Escape scheme (`ORG`=ORG_ESCAPE): if any general VC (index 2..NUM_VC-1) is free, the lowest free general index is granted, whatever the value of `up_i`.
- R4: Escape scheme: when every general VC is occupied, a request with `up_i`=1 may only use index 0 and one with `up_i`=0 may only use index 1. If only the other escape channel is free, the request is blocked.
- R5: A grant decided at a clock edge appears on `grant_o`, `grant_id_o` and `grant_vc_o` for exactly the following cycle. The granted bit of `busy_o` is set from that same edge on.
- R6: A `rel_i[v]` pulse clears `busy_o[v]` at the next edge. A release aimed at a VC that is not occupied changes nothing.
- R7: A VC is free for allocation in the same cycle its release strobe is high, so it can be re-granted at that edge.
- R8: Waiters are served before a new request. Among waiters, the oldest one that has an eligible free VC is granted. A waiter that cannot use any free VC keeps its position.
- R9: At most one grant is made per cycle. An accepted request that is not granted joins the wait list.
- R10: `q_full_o` is 1 exactly when QDEPTH messages are waiting. A request presented while `q_full_o` is 1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A new message asks for a VC this cycle |
| req_id_i | input | ID_W | Identifier of the requesting message |
| up_i | input | 1 | Direction flag: current coordinate below the target |
| rel_i | input | NUM_VC | Per-VC release strobes |
| grant_o | output | 1 | A VC was granted at the last edge |
| grant_id_o | output | ID_W | Identifier of the message that received the VC |
| grant_vc_o | output | $clog2(NUM_VC) | Index of the granted VC |
| busy_o | output | NUM_VC | Per-VC occupancy |
| q_full_o | output | 1 | Wait list is full and new requests are dropped |

## Verification
The assertions place no constraint on the inputs. Releases may hit idle channels, and requests may arrive while the list is full, because the block must tolerate both. The only thing they take for granted is that the occupancy they observe began from the reset state. The stimulus follows directed sequences that exhaust the general channels, strand a waiter behind the wrong escape channel, and fill the wait list. It then runs a seeded random phase in which releases strike occupied and idle channels alike, and requests sometimes arrive while `q_full_o` is high. Both partitioning schemes are driven by the same stimulus and compared against a reference model in the bench.

// File: rtl/vca_pkg.sv
package vca_pkg;

    typedef enum logic {
        ORG_CLASS  = 1'b0,
        ORG_ESCAPE = 1'b1
    } vc_org_e;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;

endpackage

// File: rtl/vca_vc_pick.sv
module vca_vc_pick
    import vca_pkg::*;
#(
    parameter int      NUM_VC  = 5,
    parameter int      LOW_CNT = 2,
    parameter vc_org_e ORG     = ORG_ESCAPE
) (
    input  logic [NUM_VC-1:0]         free_i,
    input  logic                      up_i,
    output logic                      ok_o,
    output logic [$clog2(NUM_VC)-1:0] vc_o
);
    localparam int VC_W = $clog2(NUM_VC);
    localparam logic [NUM_VC-1:0] LOW_MASK = (NUM_VC'(1) << LOW_CNT) - NUM_VC'(1);
    localparam logic [NUM_VC-1:0] GEN_MASK = ~NUM_VC'(3);

    logic [NUM_VC-1:0] cand;
    logic [VC_W-1:0]   low_idx;

    // lowest set bit of the candidate vector
    always_comb begin
        low_idx = '0;
        for (int v = NUM_VC - 1; v >= 0; v--) begin
            if (cand[v]) low_idx = VC_W'(v);
        end
    end

    generate
        if (ORG == ORG_CLASS) begin : g_class
            always_comb begin
                cand = free_i & (up_i ? ~LOW_MASK : LOW_MASK);
                ok_o = |cand;
                vc_o = low_idx;
            end
        end else begin : g_escape
            always_comb begin
                cand = free_i & GEN_MASK;
                if (|cand) begin
                    ok_o = 1'b1;
                    vc_o = low_idx;
                end else begin
                    ok_o = up_i ? free_i[0] : free_i[1];
                    vc_o = up_i ? VC_W'(0) : VC_W'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/vca_wait_queue.sv
module vca_wait_queue #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 4,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [ID_W-1:0]  push_id_i,
    input  logic             push_up_i,
    input  logic             pop_i,
    input  logic [IDX_W-1:0] pop_idx_i,
    output logic [DEPTH-1:0] vld_o,
    output logic [DEPTH-1:0] up_o,
    output logic [ID_W-1:0]  id_o [DEPTH]
);
    logic [DEPTH-1:0] vld_q, vld_n, up_q, up_n;
    logic [ID_W-1:0]  id_q [DEPTH];
    logic [ID_W-1:0]  id_n [DEPTH];

    // entry 0 is the oldest; a pop closes the gap, a push lands behind the last entry
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src = (pop_i && i >= int'(pop_idx_i)) ? i + 1 : i;
            if (src < DEPTH) begin
                vld_n[i] = vld_q[src];
                up_n[i]  = up_q[src];
                id_n[i]  = id_q[src];
            end else begin
                vld_n[i] = 1'b0;
                up_n[i]  = 1'b0;
                id_n[i]  = '0;
            end
        end
        if (push_i) begin
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (!vld_n[i] && (i == 0 || vld_n[(i > 0) ? i - 1 : 0])) begin
                    vld_n[i] = 1'b1;
                    up_n[i]  = push_up_i;
                    id_n[i]  = push_id_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            up_q  <= '0;
            for (int i = 0; i < DEPTH; i++) id_q[i] <= '0;
        end else begin
            vld_q <= vld_n;
            up_q  <= up_n;
            for (int i = 0; i < DEPTH; i++) id_q[i] <= id_n[i];
        end
    end

    assign vld_o = vld_q;
    assign up_o  = up_q;
    always_comb for (int i = 0; i < DEPTH; i++) id_o[i] = id_q[i];

endmodule

// File: rtl/vc_escape_alloc.sv
module vc_escape_alloc
    import vca_pkg::*;
#(
    parameter int      NUM_VC  = 5,
    parameter int      LOW_CNT = 2,
    parameter int      QDEPTH  = 4,
    parameter int      ID_W    = 4,
    parameter vc_org_e ORG     = ORG_ESCAPE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid_i,
    input  logic [ID_W-1:0]           req_id_i,
    input  logic                      up_i,
    input  logic [NUM_VC-1:0]         rel_i,
    output logic                      grant_o,
    output logic [ID_W-1:0]           grant_id_o,
    output logic [$clog2(NUM_VC)-1:0] grant_vc_o,
    output logic [NUM_VC-1:0]         busy_o,
    output logic                      q_full_o
);
    localparam int VC_W  = $clog2(NUM_VC);
    localparam int IDX_W = $clog2(QDEPTH);

    q_state_e          state_q, state_n;
    logic [NUM_VC-1:0] busy_q, busy_n, free_w;
    logic [QDEPTH-1:0] ent_vld, ent_up, ent_ok;
    logic [ID_W-1:0]   ent_id [QDEPTH];
    logic [VC_W-1:0]   ent_vc [QDEPTH];
    logic              new_ok;
    logic [VC_W-1:0]   new_vc;
    logic              wait_hit, accept, push, pop, grant_n;
    logic [IDX_W-1:0]  wait_sel;
    logic [VC_W-1:0]   wait_vc, gvc_n;
    logic [ID_W-1:0]   wait_id, gid_n;

    // a channel released this cycle is already usable
    assign free_w = ~busy_q | rel_i;

    vca_wait_queue #(.DEPTH(QDEPTH), .ID_W(ID_W), .IDX_W(IDX_W)) wq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push),
        .push_id_i(req_id_i),
        .push_up_i(up_i),
        .pop_i    (pop),
        .pop_idx_i(wait_sel),
        .vld_o    (ent_vld),
        .up_o     (ent_up),
        .id_o     (ent_id)
    );

    generate
        for (genvar e = 0; e < QDEPTH; e++) begin : g_wait_pick
            vca_vc_pick #(.NUM_VC(NUM_VC), .LOW_CNT(LOW_CNT), .ORG(ORG)) pick_i (
                .free_i(free_w),
                .up_i  (ent_up[e]),
                .ok_o  (ent_ok[e]),
                .vc_o  (ent_vc[e])
            );
        end
    endgenerate

    vca_vc_pick #(.NUM_VC(NUM_VC), .LOW_CNT(LOW_CNT), .ORG(ORG)) new_pick_i (
        .free_i(free_w),
        .up_i  (up_i),
        .ok_o  (new_ok),
        .vc_o  (new_vc)
    );

    // oldest waiter with a usable channel, then the new request
    always_comb begin
        wait_hit = 1'b0;
        wait_sel = '0;
        wait_vc  = '0;
        wait_id  = '0;
        for (int e = QDEPTH - 1; e >= 0; e--) begin
            if (ent_vld[e] && ent_ok[e]) begin
                wait_hit = 1'b1;
                wait_sel = IDX_W'(e);
                wait_vc  = ent_vc[e];
                wait_id  = ent_id[e];
            end
        end
        accept  = req_valid_i && (state_q != Q_FULL);
        grant_n = wait_hit || (accept && new_ok);
        gvc_n   = wait_hit ? wait_vc : new_vc;
        gid_n   = wait_hit ? wait_id : req_id_i;
        pop     = wait_hit;
        push    = accept && (wait_hit || !new_ok);
        busy_n  = (busy_q & ~rel_i) | (grant_n ? (NUM_VC'(1) << gvc_n) : '0);
    end

    // occupancy state machine of the wait list
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            Q_EMPTY: if (push) state_n = Q_PART;                                   // FIRST_WAIT
            Q_PART: begin
                if (push && !pop && ent_vld[QDEPTH-2]) state_n = Q_FULL;          // FILL
                else if (pop && !push && !ent_vld[1]) state_n = Q_EMPTY;          // DRAIN
            end
            Q_FULL:  if (pop && !push) state_n = Q_PART;                           // ROOM
            default: state_n = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q     <= '0;
            grant_o    <= 1'b0;
            grant_id_o <= '0;
            grant_vc_o <= '0;
        end else begin
            busy_q     <= busy_n;
            grant_o    <= grant_n;
            grant_id_o <= grant_n ? gid_n : '0;
            grant_vc_o <= grant_n ? gvc_n : '0;
        end
    end

    always_comb begin
        busy_o   = busy_q;
        q_full_o = (state_q == Q_FULL);
    end

endmodule

// File: rtl/vc_escape_alloc_chk.sv
module vc_escape_alloc_chk
    import vca_pkg::*;
#(
    parameter int      NUM_VC = 5,
    parameter vc_org_e ORG    = ORG_ESCAPE
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_VC-1:0]         rel_i,
    input logic                      grant_o,
    input logic [$clog2(NUM_VC)-1:0] grant_vc_o,
    input logic [NUM_VC-1:0]         busy_o,
    input logic                      q_full_o
);
    logic [NUM_VC-1:0] held_q;

    // channels that were occupied and not released at the last edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= busy_o & ~rel_i;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (busy_o == '0 && !grant_o && !q_full_o));

    assert_grant_marks_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> busy_o[grant_vc_o]);

    assert_grant_only_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> !held_q[grant_vc_o]);

    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy_o & ~$past(busy_o)) <= 1);

    assert_full_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_full_o) |-> !grant_o);

    generate
        if (ORG == ORG_ESCAPE && NUM_VC > 2) begin : g_esc
            assert_escape_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_o && grant_vc_o < 2) |-> (&held_q[NUM_VC-1:2]));
        end
    endgenerate

endmodule

bind vc_escape_alloc vc_escape_alloc_chk #(.NUM_VC(NUM_VC), .ORG(ORG)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rel_i     (rel_i),
    .grant_o   (grant_o),
    .grant_vc_o(grant_vc_o),
    .busy_o    (busy_o),
    .q_full_o  (q_full_o)
);

// File: tb/vc_escape_alloc_tb.sv
`timescale 1ns/1ps
module vc_escape_alloc_tb_top;
    import vca_pkg::*;

    localparam int NV = 5;
    localparam int L1 = 2;
    localparam int QD = 4;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [IW-1:0] req_id = '0;
    logic up = 1'b0;
    logic [NV-1:0] rel = '0;

    logic e_g, c_g, e_full, c_full;
    logic [IW-1:0] e_id, c_id;
    logic [2:0] e_vc, c_vc;
    logic [NV-1:0] e_busy, c_busy;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vc_escape_alloc #(.NUM_VC(NV), .LOW_CNT(L1), .QDEPTH(QD), .ID_W(IW), .ORG(ORG_ESCAPE)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_id_i(req_id), .up_i(up),
        .rel_i(rel), .grant_o(e_g), .grant_id_o(e_id), .grant_vc_o(e_vc),
        .busy_o(e_busy), .q_full_o(e_full));

    vc_escape_alloc #(.NUM_VC(NV), .LOW_CNT(L1), .QDEPTH(QD), .ID_W(IW), .ORG(ORG_CLASS)) dut_c_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_id_i(req_id), .up_i(up),
        .rel_i(rel), .grant_o(c_g), .grant_id_o(c_id), .grant_vc_o(c_vc),
        .busy_o(c_busy), .q_full_o(c_full));

    // reference model, index 0 = escape scheme, 1 = class scheme
    logic [NV-1:0] mb [2];
    int  mq_id [2][QD];
    bit  mq_up [2][QD];
    int  mqn [2];
    bit  xg [2];
    int  xid [2];
    int  xvc [2];
    logic [NV-1:0] prev_busy [2];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit pick(input int m, input bit u, input logic [NV-1:0] fr, output int vc);
        vc = 0;
        if (m == 1) begin
            for (int v = 0; v < NV; v++)
                if (fr[v] && (u ? (v >= L1) : (v < L1))) begin vc = v; return 1; end
            return 0;
        end
        for (int v = 2; v < NV; v++)
            if (fr[v]) begin vc = v; return 1; end
        vc = u ? 0 : 1;
        return fr[vc];
    endfunction

    task automatic model_step(input int m, input bit rv, input int id, input bit u, input logic [NV-1:0] rl);
        logic [NV-1:0] fr;
        int wsel, vc;
        bit acc, ok;
        fr = ~mb[m] | rl;
        wsel = -1;
        xg[m] = 0; xid[m] = 0; xvc[m] = 0;
        for (int i = 0; i < mqn[m]; i++)
            if (wsel < 0 && pick(m, mq_up[m][i], fr, vc)) begin wsel = i; xvc[m] = vc; end
        acc = rv && (mqn[m] < QD);
        if (wsel >= 0) begin
            xg[m] = 1; xid[m] = mq_id[m][wsel];
            for (int j = wsel; j < mqn[m] - 1; j++) begin
                mq_id[m][j] = mq_id[m][j+1]; mq_up[m][j] = mq_up[m][j+1];
            end
            mqn[m]--;
            if (acc) begin mq_id[m][mqn[m]] = id; mq_up[m][mqn[m]] = u; mqn[m]++; end
        end else if (acc) begin
            ok = pick(m, u, fr, vc);
            if (ok) begin xg[m] = 1; xid[m] = id; xvc[m] = vc; end
            else begin mq_id[m][mqn[m]] = id; mq_up[m][mqn[m]] = u; mqn[m]++; end
        end
        mb[m] = (mb[m] & ~rl) | (xg[m] ? (NV'(1) << xvc[m]) : '0);
    endtask

    task automatic compare(input int m, input logic g, input logic [IW-1:0] id, input logic [2:0] vc,
                           input logic [NV-1:0] bz, input logic fl);
        string vtag;
        vtag = (m == 1) ? "R2" : ((xvc[m] < 2) ? "R4" : "R3");
        chk("R5", "grant", int'(g), int'(xg[m]));
        if (xg[m]) begin
            chk(vtag, "grant_vc", int'(vc), xvc[m]);
            chk("R8", "grant_id", int'(id), xid[m]);
        end
        chk("R6", "busy", int'(bz), int'(mb[m]));
        chk("R10", "q_full", int'(fl), int'(mqn[m] == QD));
        chk("R9", "new busy bits", $countones(bz & ~prev_busy[m]) <= 1 ? 1 : 0, 1);
        prev_busy[m] = bz;
    endtask

    // drive at a falling edge, sample at the following falling edge
    task automatic step(input bit rv, input int id, input bit u, input logic [NV-1:0] rl);
        req_valid = rv; req_id = IW'(id); up = u; rel = rl;
        model_step(0, rv, id, u, rl);
        model_step(1, rv, id, u, rl);
        @(posedge clk);
        @(negedge clk);
        compare(0, e_g, e_id, e_vc, e_busy, e_full);
        compare(1, c_g, c_id, c_vc, c_busy, c_full);
        req_valid = 0; rel = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int m = 0; m < 2; m++) begin mb[m] = '0; mqn[m] = 0; prev_busy[m] = '0; end
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(e_busy | c_busy), 0);
        chk("R1", "grant in reset", int'(e_g | c_g), 0);
        chk("R1", "full in reset", int'(e_full | c_full), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", int'(e_busy | c_busy), 0);

        step(1, 1, 0, '0);
        step(1, 2, 0, '0);
        step(1, 3, 0, '0);
        chk("R2", "low group exhausted, no grant", int'(c_g), 0);
        step(1, 4, 0, '0);
        chk("R4", "escape index 1 for down request", int'(e_vc), 1);
        step(1, 5, 0, '0);
        chk("R4", "wrong escape free, blocked", int'(e_g), 0);
        step(1, 6, 1, '0);
        chk("R4", "escape index 0 for up request", int'(e_vc), 0);
        step(0, 0, 0, 5'b01000);
        chk("R7", "released VC re-granted same edge", int'(e_g && e_id == 5 && e_vc == 3), 1);
        step(1, 7, 0, '0);
        chk("R10", "full after four waiters", int'(c_full), 1);
        step(1, 8, 0, '0);
        step(0, 0, 0, 5'b00001);
        chk("R8", "oldest waiter served", int'(c_id), 3);

        for (int k = 0; k < 4000; k++) begin
            logic [NV-1:0] rl;
            for (int v = 0; v < NV; v++) rl[v] = ($urandom % 6) == 0;
            step(($urandom % 2) == 0, int'($urandom % 16), ($urandom % 2) == 0, rl);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule